// File: doc/BRIEF.md
# Memory-Mapped to Register-Bus Bridge

This bridge sits between a processor-side memory-mapped port and a chip-internal register bus. Each processor access is a 64-bit read or write. The bridge folds the byte address into a register number. It uses one of two packing modes, picked by a generation-select pin. It then either answers the access itself, for a short fixed set of registers, or forwards it downstream as a single request and waits for the response.

The processor holds its request until the bridge acknowledges it. While an access is in progress the bridge shows busy, and it never has more than one access open on the register bus. Every access that finishes raises a DONE status flag. An access that is refused or answered with an error also raises FAIL. Both flags stay set until the clear strobe is pulsed.

Top module: `mmio_regbus_bridge`

## Requirements
- R1: An access with `reqSize` other than 8 bytes is acknowledged without any downstream request. It returns zero read data and sets both FAIL and DONE.
- R2: Data lanes are big-endian. The byte in `reqWdata[7:0]` is the most significant byte of the register value. So the value sent on `dsWdata` is `reqWdata` with its bytes reversed, and `reqRdata` is the register value with its bytes reversed.
- R3: Address bits at and above position `WIN_W` (default 32) are ignored before translation.
- R4: With `genSel` = 1, the register number is the masked address shifted right by 3.
- R5: With `genSel` = 0, the register number is ((masked >> 4) with its low nibble cleared) OR ((masked >> 3) AND 0xF).
- R6: A read of register 0xF000F returns the `CHIP_ID` parameter locally. A write to it is dropped locally and completes with DONE.
- R7: Reads of registers 0x1010C00, 0x1010C03, 0x2020007, 0x2020009, 0x202000F, 0x2013028, 0x201302A, 0x2013801, 0x2013802 and 0x2013F00 to 0x2013F07 return zero locally, with no downstream request.
- R8: Writes to registers 0x1010C00 to 0x1010C05, 0x2020007, 0x2020009 and 0x202000F are dropped locally and complete with DONE only.
- R9: Every other access makes exactly one downstream request. That request carries `dsAddr` = register number << 3, `dsWrite` and the swapped data. A read returns the swapped response data.
- R10: A successful access sets DONE. A downstream error sets FAIL and DONE, and a read that fails returns zero.
- R11: DONE and FAIL are sticky: later accesses only OR into them.
- R12: `statusClr` clears both flags on the next edge and wins over a set in the same cycle.
- R13: `reqBusy` is high from the accepting edge until the acknowledge cycle ends. `reqAck` is a one-cycle pulse. `dsValid` stays high with a stable `dsAddr` until `dsReady`, and only one access is in progress at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| genSel | input | 1 | Address packing mode: 1 straight shift, 0 nibble packing |
| reqValid | input | 1 | Processor request present; held until `reqAck` |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 4 | Access size in bytes |
| reqAddr | input | ADDR_W (40) | Byte address |
| reqWdata | input | DATA_W (64) | Write data, big-endian lanes |
| reqBusy | output | 1 | Access in progress |
| reqAck | output | 1 | One-cycle completion pulse; `reqRdata` valid |
| reqRdata | output | DATA_W (64) | Read data, big-endian lanes |
| dsValid | output | 1 | Downstream request valid |
| dsReady | input | 1 | Downstream request taken |
| dsWrite | output | 1 | Downstream write flag |
| dsAddr | output | WIN_W (32) | Downstream register address (register number << 3) |
| dsWdata | output | DATA_W (64) | Downstream write value |
| dsRspValid | input | 1 | Downstream response present |
| dsRspErr | input | 1 | Downstream response reports an error |
| dsRspData | input | DATA_W (64) | Downstream read value |
| statusClr | input | 1 | Clears DONE and FAIL |
| statusDone | output | 1 | Sticky completion flag |
| statusFail | output | 1 | Sticky failure flag |

## Verification
The assertions watch the handshakes and the status flags on every cycle. They check that a downstream request is held steady until taken, that it only appears during a busy access, and that it is aligned. They also check that the acknowledge is a single pulse, that FAIL never stands without DONE, that both flags stay sticky, and that a clear takes effect. Only the bench's scenarios can show that the two packing modes pick the right register and that each fixed-list register stays local. They also show that the byte reversal is correct, that failed reads are zeroed, and that a set which lands in the same cycle as a clear is lost.

// File: rtl/mmio_regbus_bridge_pkg.sv
`timescale 1ns/1ps
package mmio_regbus_bridge_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_ACK} brState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch a downstream request
    logic loadLocal;  // load the locally answered read value
    logic loadRsp;    // load the downstream response value
  } dpStrobe_t;

  localparam logic [31:0] ID_REG = 32'h000F_000F;

  function automatic logic isReadZero(input logic [31:0] r);
    case (r)
      32'h0101_0C00, 32'h0101_0C03,
      32'h0202_0007, 32'h0202_0009, 32'h0202_000F,
      32'h0201_3028, 32'h0201_302A,
      32'h0201_3801, 32'h0201_3802: return 1'b1;
      default: return ({r[31:3], 3'b000} == 32'h0201_3F00);
    endcase
  endfunction

  function automatic logic isWriteDrop(input logic [31:0] r);
    case (r)
      ID_REG, 32'h0202_0007, 32'h0202_0009, 32'h0202_000F: return 1'b1;
      default: return (r >= 32'h0101_0C00) && (r <= 32'h0101_0C05);
    endcase
  endfunction

endpackage

// File: rtl/mmio_regbus_bridge_xlate.sv
`timescale 1ns/1ps
module mmio_regbus_bridge_xlate #(
  parameter int ADDR_W = 40,
  parameter int WIN_W  = 32
) (
  input  logic              genSel,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [WIN_W-4:0]  regAddr
);
  logic [WIN_W-1:0] masked;
  logic [WIN_W-4:0] shiftReg;
  logic [WIN_W-4:0] packReg;

  assign masked   = busAddr[WIN_W-1:0];
  assign shiftReg = masked[WIN_W-1:3];
  // upper part keeps bits from position 8 up, low nibble from bits 6..3
  assign packReg  = {1'b0, masked[WIN_W-1:8], masked[6:3]};
  assign regAddr  = genSel ? shiftReg : packReg;

  logic unusedBits;
  if (ADDR_W > WIN_W) begin : gHi
    assign unusedBits = ^{busAddr[ADDR_W-1:WIN_W], masked[2:0]};
  end else begin : gNoHi
    assign unusedBits = ^masked[2:0];
  end
endmodule

// File: rtl/mmio_regbus_bridge_dp.sv
`timescale 1ns/1ps
module mmio_regbus_bridge_dp
  import mmio_regbus_bridge_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int WIN_W  = 32,
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] CHIP_ID = 64'h0000_0002_20D5_1049,
  localparam int NBYTES = DATA_W / 8,
  localparam int SIZE_W = $clog2(NBYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genSel,
  input  logic              reqWrite,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  dpStrobe_t         strobe,
  input  logic              dsRspErr,
  input  logic [DATA_W-1:0] dsRspData,
  output logic              localHit,
  output logic              localFail,
  output logic              dsWrite,
  output logic [WIN_W-1:0]  dsAddr,
  output logic [DATA_W-1:0] dsWdata,
  output logic [DATA_W-1:0] reqRdata
);
  logic [WIN_W-4:0]  regAddr;
  logic [31:0]       regKey;
  logic              sizeOk;
  logic              isId;
  logic [DATA_W-1:0] localVal;
  logic [DATA_W-1:0] wdSwap;
  logic [DATA_W-1:0] rspSwap;
  logic [DATA_W-1:0] locSwap;

  mmio_regbus_bridge_xlate #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) uXlate (
    .genSel (genSel),
    .busAddr(reqAddr),
    .regAddr(regAddr)
  );

  assign regKey    = 32'(regAddr);
  assign sizeOk    = (reqSize == SIZE_W'(NBYTES));
  assign isId      = (regKey == ID_REG);
  assign localFail = !sizeOk;
  assign localHit  = !sizeOk ||
                     (reqWrite ? isWriteDrop(regKey) : (isId || isReadZero(regKey)));
  assign localVal  = (sizeOk && !reqWrite && isId) ? CHIP_ID : '0;

  // big-endian lanes: reverse bytes in both directions
  for (genvar b = 0; b < NBYTES; b++) begin : gSwap
    assign wdSwap[8*b +: 8]  = reqWdata[8*(NBYTES-1-b) +: 8];
    assign rspSwap[8*b +: 8] = dsRspData[8*(NBYTES-1-b) +: 8];
    assign locSwap[8*b +: 8] = localVal[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dsWrite  <= 1'b0;
      dsAddr   <= '0;
      dsWdata  <= '0;
      reqRdata <= '0;
    end else begin
      if (strobe.capture) begin
        dsWrite <= reqWrite;
        dsAddr  <= {regAddr, 3'b000};
        dsWdata <= wdSwap;
      end
      if (strobe.loadLocal) begin
        reqRdata <= locSwap;
      end else if (strobe.loadRsp) begin
        reqRdata <= (dsRspErr || dsWrite) ? '0 : rspSwap;
      end
    end
  end
endmodule

// File: rtl/mmio_regbus_bridge_ctrl.sv
`timescale 1ns/1ps
module mmio_regbus_bridge_ctrl
  import mmio_regbus_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      localHit,
  input  logic      localFail,
  input  logic      dsReady,
  input  logic      dsRspValid,
  input  logic      dsRspErr,
  input  logic      statusClr,
  output dpStrobe_t strobe,
  output logic      reqBusy,
  output logic      reqAck,
  output logic      dsValid,
  output logic      statusDone,
  output logic      statusFail
);
  brState_t state, stateNext;
  logic     setDone, setFail;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    setDone   = 1'b0;
    setFail   = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (localHit) begin
          strobe.loadLocal = 1'b1;
          setDone          = 1'b1;
          setFail          = localFail;
          stateNext        = ST_ACK;
        end else begin
          strobe.capture = 1'b1;
          stateNext      = ST_ISSUE;
        end
      end
      ST_ISSUE: if (dsReady) stateNext = ST_WAIT;
      ST_WAIT: if (dsRspValid) begin
        strobe.loadRsp = 1'b1;
        setDone        = 1'b1;
        setFail        = dsRspErr;
        stateNext      = ST_ACK;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      statusDone <= 1'b0;
      statusFail <= 1'b0;
    end else begin
      state <= stateNext;
      if (statusClr) begin
        statusDone <= 1'b0;
        statusFail <= 1'b0;
      end else begin
        statusDone <= statusDone | setDone;
        statusFail <= statusFail | setFail;
      end
    end
  end

  assign reqBusy = (state != ST_IDLE);
  assign reqAck  = (state == ST_ACK);
  assign dsValid = (state == ST_ISSUE);
endmodule

// File: rtl/mmio_regbus_bridge.sv
`timescale 1ns/1ps
module mmio_regbus_bridge
  import mmio_regbus_bridge_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int WIN_W  = 32,
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] CHIP_ID = 64'h0000_0002_20D5_1049
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           genSel,
  input  logic                           reqValid,
  input  logic                           reqWrite,
  input  logic [$clog2(DATA_W/8):0]      reqSize,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [DATA_W-1:0]              reqWdata,
  output logic                           reqBusy,
  output logic                           reqAck,
  output logic [DATA_W-1:0]              reqRdata,
  output logic                           dsValid,
  input  logic                           dsReady,
  output logic                           dsWrite,
  output logic [WIN_W-1:0]               dsAddr,
  output logic [DATA_W-1:0]              dsWdata,
  input  logic                           dsRspValid,
  input  logic                           dsRspErr,
  input  logic [DATA_W-1:0]              dsRspData,
  input  logic                           statusClr,
  output logic                           statusDone,
  output logic                           statusFail
);
  dpStrobe_t strobe;
  logic      localHit, localFail;

  mmio_regbus_bridge_dp #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID)
  ) uDp (
    .clk(clk), .rstN(rstN), .genSel(genSel), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strobe(strobe), .dsRspErr(dsRspErr), .dsRspData(dsRspData),
    .localHit(localHit), .localFail(localFail), .dsWrite(dsWrite),
    .dsAddr(dsAddr), .dsWdata(dsWdata), .reqRdata(reqRdata)
  );

  mmio_regbus_bridge_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .localHit(localHit),
    .localFail(localFail), .dsReady(dsReady), .dsRspValid(dsRspValid),
    .dsRspErr(dsRspErr), .statusClr(statusClr), .strobe(strobe),
    .reqBusy(reqBusy), .reqAck(reqAck), .dsValid(dsValid),
    .statusDone(statusDone), .statusFail(statusFail)
  );
endmodule

// File: rtl/mmio_regbus_bridge_chk.sv
`timescale 1ns/1ps
module mmio_regbus_bridge_chk #(
  parameter int WIN_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqBusy,
  input logic             reqAck,
  input logic             dsValid,
  input logic             dsReady,
  input logic [WIN_W-1:0] dsAddr,
  input logic             statusClr,
  input logic             statusDone,
  input logic             statusFail
);
  p_ds_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    dsValid && !dsReady |=> dsValid && $stable(dsAddr));

  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  p_ds_in_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    dsValid |-> reqBusy && !reqAck);

  p_ds_align_r9: assert property (@(posedge clk) disable iff (!rstN)
    dsValid |-> dsAddr[2:0] == 3'b000);

  p_fail_has_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusFail |-> statusDone);

  p_sticky_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusDone && !statusClr |=> statusDone);

  p_sticky_fail_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusFail && !statusClr |=> statusFail);

  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    statusClr |=> !statusDone && !statusFail);
endmodule

bind mmio_regbus_bridge mmio_regbus_bridge_chk #(.WIN_W(WIN_W)) uChk (
  .clk(clk), .rstN(rstN), .reqBusy(reqBusy), .reqAck(reqAck),
  .dsValid(dsValid), .dsReady(dsReady), .dsAddr(dsAddr),
  .statusClr(statusClr), .statusDone(statusDone), .statusFail(statusFail)
);

// File: tb/tb_mmio_regbus_bridge.sv
`timescale 1ns/1ps
module tb_mmio_regbus_bridge;
  localparam logic [63:0] TB_ID = 64'h0000_0002_20D5_1049;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genSel = 1'b1, reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0]  reqSize = 4'd8;
  logic [39:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic reqBusy, reqAck, dsValid, dsWrite, statusDone, statusFail;
  logic [63:0] reqRdata, dsWdata;
  logic [31:0] dsAddr;
  logic dsReady = 1'b0, dsRspValid = 1'b0, dsRspErr = 1'b0, statusClr = 1'b0;
  logic [63:0] dsRspData = '0;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  mmio_regbus_bridge #(.CHIP_ID(TB_ID)) dut (
    .clk(clk), .rstN(rstN), .genSel(genSel), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBusy(reqBusy), .reqAck(reqAck),
    .reqRdata(reqRdata), .dsValid(dsValid), .dsReady(dsReady),
    .dsWrite(dsWrite), .dsAddr(dsAddr), .dsWdata(dsWdata),
    .dsRspValid(dsRspValid), .dsRspErr(dsRspErr), .dsRspData(dsRspData),
    .statusClr(statusClr), .statusDone(statusDone), .statusFail(statusFail)
  );

  // vector: [39:32] high junk, [31] mode, [30] write, [29:28] kind, [27:0] register
  // kind 0: local zero / dropped, 1: identification, 2: forwarded
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 1'b0, 2'd1, 28'h00F000F},
    {8'h00, 1'b0, 1'b0, 2'd1, 28'h00F000F},
    {8'h00, 1'b1, 1'b1, 2'd0, 28'h00F000F},
    {8'h00, 1'b1, 1'b0, 2'd0, 28'h1010C00},
    {8'h00, 1'b0, 1'b0, 2'd0, 28'h2013F05},
    {8'h00, 1'b1, 1'b0, 2'd0, 28'h201302A},
    {8'h00, 1'b0, 1'b1, 2'd0, 28'h1010C04},
    {8'h00, 1'b1, 1'b1, 2'd0, 28'h202000F},
    {8'h00, 1'b1, 1'b0, 2'd2, 28'h1010C01},
    {8'h00, 1'b0, 1'b1, 2'd2, 28'h2013F00},
    {8'hC3, 1'b1, 1'b0, 2'd2, 28'h0123456},
    {8'h5A, 1'b0, 1'b0, 2'd2, 28'h0ABCDE9},
    {8'h00, 1'b1, 1'b1, 2'd2, 28'h2013802},
    {8'h00, 1'b0, 1'b0, 2'd0, 28'h2013801}
  };

  function automatic logic [63:0] swap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic logic [39:0] mkAddr(input logic gen, input logic [27:0] rg,
                                         input logic [7:0] junk);
    logic [31:0] a;
    if (gen) a = {1'b0, rg, 3'b000};
    else     a = ({4'h0, rg & 28'hFFFFFF0} << 4) | {25'h0, rg[3:0], 3'b000};
    return {junk, a};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clrPulse();
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
  endtask

  task automatic doAccess(input logic gen, input logic wr, input logic [39:0] addr,
                          input logic [63:0] wd, input logic [3:0] sz,
                          input logic err, input int stall,
                          output logic [63:0] rd, output logic sawDs,
                          output logic [31:0] dsA, output logic dsW,
                          output logic [63:0] dsWd, output logic busyGap);
    logic fin;
    int cnt;
    fin = 1'b0; cnt = 0; sawDs = 1'b0; busyGap = 1'b0;
    rd = '0; dsA = '0; dsW = 1'b0; dsWd = '0;
    @(negedge clk);
    genSel = gen; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    reqSize = sz; reqValid = 1'b1;
    for (int k = 0; k < 60 && !fin; k++) begin
      @(negedge clk);
      if (!reqBusy) busyGap = 1'b1;
      dsRspValid = 1'b0;
      if (reqAck) begin
        rd = reqRdata; reqValid = 1'b0; fin = 1'b1;
      end else if (dsReady) begin
        dsReady = 1'b0; dsRspValid = 1'b1; dsRspErr = err;
        dsRspData = 64'hA5A5_0000_0000_0000 | {32'h0, dsA};
      end else if (dsValid) begin
        if (!sawDs) begin
          sawDs = 1'b1; dsA = dsAddr; dsW = dsWrite; dsWd = dsWdata;
        end
        if (cnt >= stall) dsReady = 1'b1;
        else cnt++;
      end
    end
    if (!fin) begin
      reqValid = 1'b0;
      check(1'b0, "R13 access never acknowledged", 64'h0, 64'h1);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, dsWd, wd, expRd;
    logic sawDs, dsW, busyGap;
    logic [31:0] dsA;
    repeat (3) @(negedge clk);
    // reset state
    check(!reqBusy && !reqAck && !dsValid && !statusDone && !statusFail,
          "R13 reset outputs idle",
          {59'h0, reqBusy, reqAck, dsValid, statusDone, statusFail}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic gen, wr;
      logic [1:0] kind;
      logic [27:0] rg;
      gen = VEC[i][31]; wr = VEC[i][30]; kind = VEC[i][29:28]; rg = VEC[i][27:0];
      wd = 64'h0102_0304_0506_0708 + 64'(i) * 64'h0011_0000_0000_0100;
      clrPulse();
      doAccess(gen, wr, mkAddr(gen, rg, VEC[i][39:32]), wd, 4'd8, 1'b0, 0,
               rd, sawDs, dsA, dsW, dsWd, busyGap);
      if (kind == 2'd2) begin
        // R3 R4 R5 R9: forwarded with register << 3
        check(sawDs, $sformatf("R9 vec%0d forwarded", i), {63'h0, sawDs}, 64'h1);
        check(dsA == {1'b0, rg, 3'b000}, $sformatf("R4 R5 R3 vec%0d dsAddr", i),
              {32'h0, dsA}, {33'h0, rg, 3'b000});
        check(dsW == wr, $sformatf("R9 vec%0d dsWrite", i), {63'h0, dsW}, {63'h0, wr});
        if (wr) begin
          check(dsWd == swap64(wd), $sformatf("R2 vec%0d dsWdata", i), dsWd, swap64(wd));
          expRd = '0;
        end else begin
          expRd = swap64(64'hA5A5_0000_0000_0000 | {33'h0, rg, 3'b000});
        end
      end else begin
        // R6 R7 R8: handled locally
        check(!sawDs, $sformatf("R7 R8 vec%0d no downstream", i),
              {63'h0, sawDs}, 64'h0);
        expRd = (kind == 2'd1 && !wr) ? swap64(TB_ID) : 64'h0;
      end
      check(rd == expRd, $sformatf("R6 R7 R2 vec%0d read data", i), rd, expRd);
      check(statusDone && !statusFail, $sformatf("R10 vec%0d status", i),
            {62'h0, statusDone, statusFail}, 64'h2);
      check(!busyGap, $sformatf("R13 vec%0d busy held", i), {63'h0, busyGap}, 64'h0);
    end

    // R10: downstream error on read
    clrPulse();
    doAccess(1'b1, 1'b0, mkAddr(1'b1, 28'h0333330, 8'h0), '0, 4'd8, 1'b1, 0,
             rd, sawDs, dsA, dsW, dsWd, busyGap);
    check(rd == 64'h0, "R10 failed read returns zero", rd, 64'h0);
    check(statusDone && statusFail, "R10 error sets fail and done",
          {62'h0, statusDone, statusFail}, 64'h3);

    // R11: success afterwards keeps FAIL
    doAccess(1'b1, 1'b0, mkAddr(1'b1, 28'h0333338, 8'h0), '0, 4'd8, 1'b0, 0,
             rd, sawDs, dsA, dsW, dsWd, busyGap);
    check(statusFail && statusDone, "R11 fail sticky after success",
          {62'h0, statusDone, statusFail}, 64'h3);

    // R12: plain clear
    clrPulse();
    @(negedge clk);
    check(!statusDone && !statusFail, "R12 clear strobe",
          {62'h0, statusDone, statusFail}, 64'h0);

    // R12: clear held across the set edge wins
    statusClr = 1'b1;
    doAccess(1'b1, 1'b0, mkAddr(1'b1, 28'h00F000F, 8'h0), '0, 4'd8, 1'b0, 0,
             rd, sawDs, dsA, dsW, dsWd, busyGap);
    check(!statusDone, "R12 clear beats set", {63'h0, statusDone}, 64'h0);
    statusClr = 1'b0;
    @(negedge clk);
    check(!statusDone && !statusFail, "R12 no late set",
          {62'h0, statusDone, statusFail}, 64'h0);

    // R1: wrong size refused locally
    doAccess(1'b1, 1'b0, mkAddr(1'b1, 28'h0444440, 8'h0), '0, 4'd4, 1'b0, 0,
             rd, sawDs, dsA, dsW, dsWd, busyGap);
    check(!sawDs, "R1 bad size no downstream", {63'h0, sawDs}, 64'h0);
    check(rd == 64'h0, "R1 bad size read zero", rd, 64'h0);
    check(statusDone && statusFail, "R1 bad size sets fail",
          {62'h0, statusDone, statusFail}, 64'h3);

    // R13: stalled downstream, request held and busy
    clrPulse();
    wd = 64'h1122_3344_5566_7788;
    doAccess(1'b0, 1'b1, mkAddr(1'b0, 28'h0765432, 8'hFF), wd, 4'd8, 1'b0, 3,
             rd, sawDs, dsA, dsW, dsWd, busyGap);
    check(sawDs && dsA == {1'b0, 28'h0765432, 3'b000}, "R13 R5 stalled request address",
          {32'h0, dsA}, {33'h0, 28'h0765432, 3'b000});
    check(!busyGap, "R13 busy through stall", {63'h0, busyGap}, 64'h0);
    check(dsWd == swap64(wd), "R2 stalled write data", dsWd, swap64(wd));
    @(negedge clk);
    check(!reqBusy && !reqAck, "R13 idle after ack",
          {62'h0, reqBusy, reqAck}, 64'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule